// File: doc/BRIEF.md
# UART DMA Request and Completion Interrupt Logic

This block is the part of a UART that talks to a DMA controller. It does not move any data. It watches the state of the transmit and receive paths: a holding-register-empty flag, a byte-available flag and the FIFO fill counts, together with a FIFO enable. From these it drives request lines toward the DMA. When the FIFOs are off, it raises a single request for each byte. When the FIFOs are on, it raises a burst request whenever the fill reaches a programmable fraction of the 16-entry depth.

The DMA controller returns one done pulse for each direction when a whole transfer has finished. The block latches each pulse into a raw status bit. The raw bits are gated by mask bits to form a single interrupt line. Software clears a status bit by writing one to it.

A small register port holds the following, each at its own address:
- the mask,
- the raw status,
- the masked status,
- the clear register,
- the trigger-level select.

No data stream crosses the block's edge, so it has no valid/ready pair. The request lines act as the back-pressure rule. A request stays high for as long as its condition holds, and it drops on its own once the DMA has moved enough data to remove the condition.

Top module: `uart_dma_irq`

## Requirements
- R1: After reset the mask (address 0) and the raw status (address 1) read 0, the level select (address 4) reads code 2 (8 entries), and `irq` is low.
- R2: With `fifo_en` low, `tx_single_req` equals `tx_hold_empty`, `rx_single_req` equals `rx_byte_avail`, and both burst requests are low.
- R3: With `fifo_en` high, `rx_burst_req` is high exactly when `rx_fill` is greater than or equal to the selected level, and `rx_single_req` is low.
- R4: With `fifo_en` high, `tx_burst_req` is high exactly when `tx_fill` is less than or equal to the selected level, and `tx_single_req` is low.
- R5: Level codes written to bits [2:0] of address 4 select these thresholds: code 0 selects 2 entries, code 1 selects 4, code 2 selects 8, code 3 selects 12 and code 4 selects 14. A write of code 5, 6 or 7 leaves the level unchanged.
- R6: A high cycle on `tx_dma_done` sets raw bit 0, and a high cycle on `rx_dma_done` sets raw bit 1. The bit is visible on the clock edge that samples the pulse, and it stays set until it is cleared.
- R7: Writing to address 3 clears each raw bit whose data bit is 1, and leaves the bits whose data bit is 0 unchanged. A done pulse in the same cycle keeps its bit set.
- R8: Address 2 reads the raw status ANDed with the mask (bit 0 TX, bit 1 RX). `irq` is high exactly when that value is non-zero.
- R9: Address 0 stores the mask in bits [1:0]. Unused bits and unmapped addresses read 0. Address 3 always reads 0. Writes to addresses 1 and 2 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | FIFOs enabled; selects burst instead of single requests |
| tx_hold_empty | input | 1 | Transmit holding register is empty (FIFO off) |
| rx_byte_avail | input | 1 | A received byte is waiting (FIFO off) |
| tx_fill | input | 5 | Transmit FIFO fill count, 0 to 16 |
| rx_fill | input | 5 | Receive FIFO fill count, 0 to 16 |
| tx_dma_done | input | 1 | Transmit transfer-complete pulse from the DMA |
| rx_dma_done | input | 1 | Receive transfer-complete pulse from the DMA |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational on `reg_addr` |
| tx_single_req | output | 1 | Transmit single request |
| tx_burst_req | output | 1 | Transmit burst request |
| rx_single_req | output | 1 | Receive single request |
| rx_burst_req | output | 1 | Receive burst request |
| irq | output | 1 | Interrupt: any masked done status set |

## Verification
The assertions check several rules on every cycle:
- a done pulse always sets its status bit on the next edge;
- a clear with no competing pulse always empties its bit;
- the status holds steady when neither a pulse nor a clear arrives;
- a write of an unused level code never changes the level;
- no direction ever raises a single and a burst request together.

Other behaviours can only be shown by the bench scenarios, because they depend on the values chosen for each case:
- the exact threshold boundaries for each of the five level codes;
- the switch between single and burst requests as `fifo_en` toggles;
- a clear and a done pulse colliding in the same cycle;
- the masked read-back and `irq` under changing masks.

// File: rtl/uart_dma_pkg.sv
package uart_dma_pkg;
  typedef enum logic [2:0] {
    LVL_EIGHTH   = 3'd0,
    LVL_QUARTER  = 3'd1,
    LVL_HALF     = 3'd2,
    LVL_3QUARTER = 3'd3,
    LVL_7EIGHTH  = 3'd4
  } lvl_e;

  localparam int unsigned NDIR     = 2;
  localparam int unsigned DIR_TX   = 0;
  localparam int unsigned DIR_RX   = 1;

  localparam int unsigned A_MASK   = 0;
  localparam int unsigned A_RAW    = 1;
  localparam int unsigned A_MSTAT  = 2;
  localparam int unsigned A_CLEAR  = 3;
  localparam int unsigned A_LEVEL  = 4;
endpackage

// File: rtl/uart_dma_req.sv
module uart_dma_req
  import uart_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter bit          IS_RX = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             avail,
  input  logic [CNT_W-1:0] fill,
  input  lvl_e             lvl_code,
  output logic             single_req,
  output logic             burst_req
);
  localparam logic [CNT_W-1:0] TH0 = CNT_W'(DEPTH / 8);
  localparam logic [CNT_W-1:0] TH1 = CNT_W'(DEPTH / 4);
  localparam logic [CNT_W-1:0] TH2 = CNT_W'(DEPTH / 2);
  localparam logic [CNT_W-1:0] TH3 = CNT_W'((DEPTH * 3) / 4);
  localparam logic [CNT_W-1:0] TH4 = CNT_W'((DEPTH * 7) / 8);

  logic [CNT_W-1:0] thresh;
  logic             level_hit;

  always_comb begin
    case (lvl_code)
      LVL_EIGHTH:   thresh = TH0;
      LVL_QUARTER:  thresh = TH1;
      LVL_HALF:     thresh = TH2;
      LVL_3QUARTER: thresh = TH3;
      default:      thresh = TH4;
    endcase
  end

  generate
    if (IS_RX) begin : g_rx
      assign level_hit = (fill >= thresh);
    end else begin : g_tx
      assign level_hit = (fill <= thresh);
    end
  endgenerate

  assign single_req = !fifo_en && avail;
  assign burst_req  = fifo_en && level_hit;

  // R2 R3 R4
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({single_req, burst_req}));
endmodule

// File: rtl/uart_dma_stat.sv
module uart_dma_stat
  import uart_dma_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NDIR-1:0] done,
  input  logic [NDIR-1:0] clr,
  input  logic [NDIR-1:0] mask,
  output logic [NDIR-1:0] raw,
  output logic            irq
);
  generate
    for (genvar d = 0; d < NDIR; d++) begin : g_dir
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       raw[d] <= 1'b0;
        else if (done[d]) raw[d] <= 1'b1;
        else if (clr[d])  raw[d] <= 1'b0;
      end

      // R6 R7
      done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done[d] |=> raw[d]);

      // R7
      clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr[d] && !done[d]) |=> !raw[d]);

      // R6
      status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr[d] && !done[d]) |=> $stable(raw[d]));
    end
  endgenerate

  assign irq = |(raw & mask);
endmodule

// File: rtl/uart_dma_regs.sv
module uart_dma_regs
  import uart_dma_pkg::*;
#(
  parameter int unsigned AW = 3,
  parameter int unsigned DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NDIR-1:0] raw,
  output logic [NDIR-1:0] mask,
  output lvl_e            lvl_code,
  output logic [NDIR-1:0] clr,
  output logic [DW-1:0]   rdata
);
  logic sel_mask, sel_clear, sel_level, code_ok;
  logic unused_wbits;

  assign sel_mask  = (addr == AW'(A_MASK));
  assign sel_clear = (addr == AW'(A_CLEAR));
  assign sel_level = (addr == AW'(A_LEVEL));
  assign code_ok   = (wdata[2:0] <= 3'(LVL_7EIGHTH));
  assign unused_wbits = ^wdata[DW-1:3];

  assign clr = (wr_en && sel_clear) ? wdata[NDIR-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '0;
      lvl_code <= LVL_HALF;
    end else if (wr_en) begin
      if (sel_mask)             mask     <= wdata[NDIR-1:0];
      if (sel_level && code_ok) lvl_code <= lvl_e'(wdata[2:0]);
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(A_MASK):  rdata[NDIR-1:0] = mask;
      AW'(A_RAW):   rdata[NDIR-1:0] = raw;
      AW'(A_MSTAT): rdata[NDIR-1:0] = raw & mask;
      AW'(A_LEVEL): rdata[2:0]      = lvl_code;
      default:      rdata           = '0;
    endcase
  end

  // R5
  bad_level_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_level && !code_ok) |=> $stable(lvl_code));
endmodule

// File: rtl/uart_dma_irq.sv
module uart_dma_irq
  import uart_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1),
  parameter int unsigned AW    = 3,
  parameter int unsigned DW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_en,
  input  logic             tx_hold_empty,
  input  logic             rx_byte_avail,
  input  logic [CNT_W-1:0] tx_fill,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic             tx_dma_done,
  input  logic             rx_dma_done,
  input  logic             reg_wr,
  input  logic [AW-1:0]    reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             tx_single_req,
  output logic             tx_burst_req,
  output logic             rx_single_req,
  output logic             rx_burst_req,
  output logic             irq
);
  logic [NDIR-1:0] mask, raw, clr, done;
  lvl_e            lvl_code;

  assign done[DIR_TX] = tx_dma_done;
  assign done[DIR_RX] = rx_dma_done;

  uart_dma_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .raw(raw), .mask(mask), .lvl_code(lvl_code),
    .clr(clr), .rdata(reg_rdata)
  );

  uart_dma_stat u_stat (
    .clk(clk), .rst_n(rst_n), .done(done), .clr(clr), .mask(mask),
    .raw(raw), .irq(irq)
  );

  uart_dma_req #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b0)) u_tx_req (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .avail(tx_hold_empty),
    .fill(tx_fill), .lvl_code(lvl_code),
    .single_req(tx_single_req), .burst_req(tx_burst_req)
  );

  uart_dma_req #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IS_RX(1'b1)) u_rx_req (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .avail(rx_byte_avail),
    .fill(rx_fill), .lvl_code(lvl_code),
    .single_req(rx_single_req), .burst_req(rx_burst_req)
  );
endmodule

// File: tb/uart_dma_irq_tb.sv
`timescale 1ns/1ps
module uart_dma_irq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en = 1'b0, tx_hold_empty = 1'b0, rx_byte_avail = 1'b0;
  logic [4:0] tx_fill = '0, rx_fill = '0;
  logic       tx_dma_done = 1'b0, rx_dma_done = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       tx_single_req, tx_burst_req, rx_single_req, rx_burst_req, irq;

  int checks = 0;
  int fails  = 0;

  int m_mask = 0;
  int m_raw  = 0;
  int m_code = 2;

  always #2.5 clk = ~clk;

  uart_dma_irq u_dut (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_hold_empty(tx_hold_empty),
    .rx_byte_avail(rx_byte_avail), .tx_fill(tx_fill), .rx_fill(rx_fill),
    .tx_dma_done(tx_dma_done), .rx_dma_done(rx_dma_done), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_single_req(tx_single_req), .tx_burst_req(tx_burst_req),
    .rx_single_req(rx_single_req), .rx_burst_req(rx_burst_req), .irq(irq)
  );

  function automatic int entries(input int code);
    case (code)
      0: return 2;
      1: return 4;
      2: return 8;
      3: return 12;
      default: return 14;
    endcase
  endfunction

  function automatic int exp_rd(input int a);
    case (a)
      0: return m_mask;
      1: return m_raw;
      2: return m_raw & m_mask;
      4: return m_code;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    int thr;
    string rtag;
    thr = entries(m_code);
    chk("R2 tx_single", tx_single_req, (!fifo_en && tx_hold_empty) ? 1 : 0);
    chk("R2 rx_single", rx_single_req, (!fifo_en && rx_byte_avail) ? 1 : 0);
    chk("R4 tx_burst", tx_burst_req, (fifo_en && int'(tx_fill) <= thr) ? 1 : 0);
    chk("R3 rx_burst", rx_burst_req, (fifo_en && int'(rx_fill) >= thr) ? 1 : 0);
    chk("R8 irq", irq, ((m_raw & m_mask) != 0) ? 1 : 0);
    case (reg_addr)
      3'd1: rtag = "R6 R7 raw";
      3'd2: rtag = "R8 masked";
      3'd4: rtag = "R5 level";
      default: rtag = "R9 regs";
    endcase
    chk(rtag, int'(reg_rdata), exp_rd(int'(reg_addr)));
  endtask

  task automatic step();
    #1;
    compare_all();
    @(posedge clk);
    if (reg_wr && reg_addr == 3'd0) m_mask = int'(reg_wdata[1:0]);
    if (reg_wr && reg_addr == 3'd4 && reg_wdata[2:0] <= 3'd4) m_code = int'(reg_wdata[2:0]);
    for (int d = 0; d < 2; d++) begin
      logic dn;
      dn = (d == 0) ? tx_dma_done : rx_dma_done;
      if (dn) m_raw = m_raw | (1 << d);
      else if (reg_wr && reg_addr == 3'd3 && reg_wdata[d]) m_raw = m_raw & ~(1 << d);
    end
    @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = 8'(d);
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input int a);
    reg_addr = 3'(a);
    step();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    #1;
    chk("R1 irq", irq, 0);
    for (int a = 0; a < 5; a++) begin
      reg_addr = 3'(a);
      #1;
      chk("R1 reset reg", int'(reg_rdata), (a == 4) ? 2 : 0);
    end
    @(negedge clk);

    // R2 FIFO off, single requests follow flags
    fifo_en = 1'b0;
    for (int i = 0; i < 4; i++) begin
      tx_hold_empty = i[0]; rx_byte_avail = i[1];
      tx_fill = 5'(i * 5); rx_fill = 5'(16 - i * 5);
      rd(i);
    end

    // R3 R4 FIFO on, sweep fills at the default level
    fifo_en = 1'b1;
    tx_hold_empty = 1'b1; rx_byte_avail = 1'b1;
    for (int f = 0; f <= 16; f++) begin
      rx_fill = 5'(f); tx_fill = 5'(16 - f);
      rd(4);
    end

    // R5 each level code, boundary fills
    for (int c = 0; c < 5; c++) begin
      wr(4, c);
      for (int o = -1; o <= 1; o++) begin
        rx_fill = 5'(entries(c) + o); tx_fill = 5'(entries(c) + o);
        rd(4);
      end
    end
    // R5 unused codes ignored
    wr(4, 3);
    wr(4, 6); rd(4);
    wr(4, 7); rd(4);
    wr(4, 5); rd(4);
    rx_fill = 5'd12; tx_fill = 5'd12; rd(4);
    rx_fill = 5'd11; tx_fill = 5'd13; rd(4);

    // R9 mask register and read-only writes
    wr(0, 8'hFF); rd(0);
    wr(1, 8'h03); rd(1);
    wr(2, 8'h03); rd(2);
    rd(3); rd(5); rd(7);
    wr(0, 0); rd(0);

    // R6 done pulses set raw bits
    tx_dma_done = 1'b1; rd(1); tx_dma_done = 1'b0;
    rd(1); rd(2);
    // R8 masking
    wr(0, 2); rd(2);
    wr(0, 1); rd(2);
    rx_dma_done = 1'b1; rd(1); rx_dma_done = 1'b0;
    rd(1); rd(2);
    wr(0, 2); rd(2);
    // R7 clear one bit
    wr(3, 1); rd(1); rd(2);
    // R7 clear and done together: done wins
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 8'h02; rx_dma_done = 1'b1;
    step();
    reg_wr = 1'b0; rx_dma_done = 1'b0; reg_wdata = '0;
    rd(1); rd(2);
    // R7 clear all
    wr(3, 3); rd(1); rd(2);
    wr(0, 3);
    tx_dma_done = 1'b1; rx_dma_done = 1'b1; rd(2);
    tx_dma_done = 1'b0; rx_dma_done = 1'b0;
    rd(2);
    wr(3, 2); rd(2);
    wr(3, 1); rd(2);

    // R2 back to FIFO off
    fifo_en = 1'b0;
    tx_hold_empty = 1'b0; rx_byte_avail = 1'b1; rd(0);
    tx_hold_empty = 1'b1; rx_byte_avail = 1'b0; rd(0);

    summary();
    $finish;
  end
endmodule